// File: doc/BRIEF.md
# Low-Power Stop and Wake Controller

This block turns off the system clock enable when the processor announces a low-power stop, and turns it back on when an interrupt of high enough priority arrives or when reset is applied. The stop announcement is a one-cycle strobe that carries the processor's current 3-bit interrupt priority mask. The block keeps that mask and uses it as the threshold for waking up. All of its logic runs on a free-running reference clock that is never gated, so it can still detect a wake event while the system clock enable is low.

The block also holds one stop bit for each peripheral module. A set bit removes that module's clock enable. The bit register is clocked by the reference clock, so it can be written and read back at any time, including while the system is stopped. A module receives a clock enable only when the system is running and its own stop bit is clear.

Top module: `lpstop_wake_ctrl`

## Requirements
- R1: While rst is high, and on the edge after it, stopped reads 0, sys_clk_en reads 1, stop_bits reads all zeros, and every bit of mod_clk_en reads 1. Reset also sets the stored wake mask to 7.
- R2: A high stop_req sampled while running makes stopped go to 1 and sys_clk_en go to 0 on that same reference clock edge.
- R3: The stored mask is the value of stop_mask sampled with the accepted stop_req. Later values on stop_mask do not affect the wake decision.
- R4: While stopped, an irq_lvl strictly greater than the stored mask (levels 0 to 7, with 0 meaning no request) clears stopped and sets sys_clk_en on the first edge at which it is sampled.
- R5: While stopped, an irq_lvl of 6 or less that is less than or equal to the stored mask leaves the block stopped.
- R6: An irq_lvl of 7 wakes the block even when the stored mask is 7.
- R7: A stop_req that arrives while already stopped is ignored. It changes neither the stopped state nor the stored mask.
- R8: Asserting rst while stopped returns the block to running on that edge, whatever the stored mask is.
- R9: Bit i of stop_bits is loaded from stop_wdata when stop_wr is high. This works in both states. stop_bits always shows the stored value.
- R10: Bit i of mod_clk_en equals "running AND NOT stop_bits[i]". This means every module enable is 0 while the block is stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock, never gated |
| rst | input | 1 | Synchronous active-high reset; also a wake source |
| stop_req | input | 1 | One-cycle stop announcement strobe |
| stop_mask | input | 3 | Interrupt priority mask carried by the announcement |
| irq_lvl | input | 3 | Highest pending interrupt level, 0 = none |
| stop_wr | input | 1 | Write strobe for the module stop bits |
| stop_wdata | input | NUM_MODS | New module stop bit values |
| sys_clk_en | output | 1 | System clock enable, 1 = running |
| mod_clk_en | output | NUM_MODS | Per-module clock enables |
| stop_bits | output | NUM_MODS | Read-back of the module stop bits |
| stopped | output | 1 | 1 while the system clock is stopped |

## Verification
The bench sweeps every pair of stored mask and interrupt level, 64 pairs in all. At each pair the mask input is flipped after capture, so the test catches a comparison that is off by one (for example greater-or-equal instead of greater), a missing non-maskable case at level 7, and a mask that is not latched. It sends a second stop announcement with a higher mask while the block is stopped. A design that reloads the mask at that point would then fail to wake on an interrupt the original mask allows. Module stop bits are written while the block is stopped and then read back. This exposes a register placed on the gated clock, or module enables that stay on while the system is stopped.

// File: rtl/lpwake_pkg.sv
package lpwake_pkg;

    localparam int IPL_W = 3;

    typedef logic [IPL_W-1:0] ipl_t;

    localparam ipl_t IPL_TOP = ipl_t'((1 << IPL_W) - 1);

    typedef enum logic {
        PM_RUN  = 1'b0,
        PM_STOP = 1'b1
    } pm_state_e;

    typedef struct packed {
        logic vld;
        ipl_t mask;
    } stop_bcast_t;

    // Strictly higher than the held mask, or the top level (non-maskable).
    function automatic logic ipl_wakes(ipl_t lvl, ipl_t held);
        return (lvl > held) || (lvl == IPL_TOP);
    endfunction

endpackage

// File: rtl/lpwake_cmp.sv
module lpwake_cmp
    import lpwake_pkg::*;
(
    input  ipl_t lvl,
    input  ipl_t held_mask,
    output logic wake
);

    always_comb begin
        wake = ipl_wakes(lvl, held_mask);
    end

endmodule

// File: rtl/lpwake_fsm.sv
module lpwake_fsm
    import lpwake_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  stop_bcast_t bcast,
    input  logic        wake,
    output logic        run,
    output ipl_t        held_mask
);

    pm_state_e state_q, state_d;
    ipl_t      mask_q, mask_d;

    always_comb begin
        state_d = state_q;
        mask_d  = mask_q;
        unique case (state_q)
            PM_RUN: begin
                if (bcast.vld) begin
                    state_d = PM_STOP;
                    mask_d  = bcast.mask;
                end
            end
            PM_STOP: begin
                if (wake) begin
                    state_d = PM_RUN;
                end
            end
            default: state_d = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PM_RUN;
            mask_q  <= IPL_TOP;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
        end
    end

    assign run       = (state_q == PM_RUN);
    assign held_mask = mask_q;

    p_bcast_stops_r2: assert property (@(posedge clk) disable iff (rst)
        (run && bcast.vld) |=> !run);

    p_wake_release_r4: assert property (@(posedge clk) disable iff (rst)
        (!run && wake) |=> run);

    p_hold_stopped_r5: assert property (@(posedge clk) disable iff (rst)
        (!run && !wake) |=> !run);

    p_mask_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(mask_q));

endmodule

// File: rtl/lpwake_modgate.sv
module lpwake_modgate #(
    parameter int NUM_MODS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                wr,
    input  logic [NUM_MODS-1:0] wdata,
    output logic [NUM_MODS-1:0] stop_q,
    output logic [NUM_MODS-1:0] clk_en
);

    for (genvar i = 0; i < NUM_MODS; i++) begin : g_mod
        logic bit_q;

        always_ff @(posedge clk) begin
            if (rst)     bit_q <= 1'b0;
            else if (wr) bit_q <= wdata[i];
        end

        assign stop_q[i] = bit_q;
        assign clk_en[i] = run & ~bit_q;

        p_write_lands_r9: assert property (@(posedge clk) disable iff (rst)
            wr |=> (stop_q[i] == $past(wdata[i])));
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (stop_q == '0));

endmodule

// File: rtl/lpstop_wake_ctrl.sv
module lpstop_wake_ctrl
    import lpwake_pkg::*;
#(
    parameter int NUM_MODS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stop_req,
    input  logic [2:0]          stop_mask,
    input  logic [2:0]          irq_lvl,
    input  logic                stop_wr,
    input  logic [NUM_MODS-1:0] stop_wdata,
    output logic                sys_clk_en,
    output logic [NUM_MODS-1:0] mod_clk_en,
    output logic [NUM_MODS-1:0] stop_bits,
    output logic                stopped
);

    stop_bcast_t bcast;
    ipl_t        held_mask;
    logic        wake;
    logic        run;

    assign bcast.vld  = stop_req;
    assign bcast.mask = stop_mask;

    lpwake_cmp u_cmp (
        .lvl       (irq_lvl),
        .held_mask (held_mask),
        .wake      (wake)
    );

    lpwake_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .bcast     (bcast),
        .wake      (wake),
        .run       (run),
        .held_mask (held_mask)
    );

    lpwake_modgate #(.NUM_MODS(NUM_MODS)) u_gate (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .wr     (stop_wr),
        .wdata  (stop_wdata),
        .stop_q (stop_bits),
        .clk_en (mod_clk_en)
    );

    assign sys_clk_en = run;
    assign stopped    = ~run;

    p_nmi_wakes_r6: assert property (@(posedge clk) disable iff (rst)
        (stopped && irq_lvl == 3'd7) |=> sys_clk_en);

    p_reset_runs_r8: assert property (@(posedge clk)
        rst |=> (sys_clk_en && !stopped));

    p_mods_off_r10: assert property (@(posedge clk) disable iff (rst)
        stopped |-> (mod_clk_en == '0));

endmodule

// File: tb/lpstop_wake_ctrl_test.sv
`timescale 1ns/1ps
module lpstop_wake_ctrl_test;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         stop_req = 1'b0;
    logic [2:0]   stop_mask = 3'd0;
    logic [2:0]   irq_lvl = 3'd0;
    logic         stop_wr = 1'b0;
    logic [N-1:0] stop_wdata = '0;
    logic         sys_clk_en;
    logic [N-1:0] mod_clk_en;
    logic [N-1:0] stop_bits;
    logic         stopped;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lpstop_wake_ctrl #(.NUM_MODS(N)) uut (
        .clk        (clk),
        .rst        (rst),
        .stop_req   (stop_req),
        .stop_mask  (stop_mask),
        .irq_lvl    (irq_lvl),
        .stop_wr    (stop_wr),
        .stop_wdata (stop_wdata),
        .sys_clk_en (sys_clk_en),
        .mod_clk_en (mod_clk_en),
        .stop_bits  (stop_bits),
        .stopped    (stopped)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply inputs set at the negedge, then sample at the next negedge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic enter_stop(input logic [2:0] m);
        stop_req  = 1'b1;
        stop_mask = m;
        step();
        stop_req  = 1'b0;
        stop_mask = ~m;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        // R1 reset state
        check("R1 stopped", stopped, 0);
        check("R1 sys_clk_en", sys_clk_en, 1);
        check("R1 stop_bits", stop_bits, 0);
        check("R1 mod_clk_en", mod_clk_en, 4'hF);
        rst = 1'b0;
        step();

        // R2 R3 R4 R5 R6: every mask against every level
        for (int m = 0; m < 8; m++) begin
            for (int l = 0; l < 8; l++) begin
                irq_lvl = 3'd0;
                enter_stop(3'(m));
                check("R2 stopped after bcast", stopped, 1);
                check("R2 sys_clk_en after bcast", sys_clk_en, 0);
                irq_lvl = 3'(l);
                step();
                begin
                    logic exp_stop;
                    exp_stop = !((l > m) || (l == 7));
                    if (l == 7)      check("R6 level 7 wakes", stopped, exp_stop);
                    else if (l > m)  check("R4 R3 higher level wakes", stopped, exp_stop);
                    else             check("R5 R3 masked level holds", stopped, exp_stop);
                    check("R4 sys_clk_en", sys_clk_en, !exp_stop);
                end
                if (stopped) begin
                    irq_lvl = 3'd7;
                    step();
                end
                irq_lvl = 3'd0;
            end
        end

        // R7: second broadcast while stopped is ignored
        enter_stop(3'd2);
        stop_req = 1'b1; stop_mask = 3'd6;
        step();
        stop_req = 1'b0;
        check("R7 still stopped", stopped, 1);
        irq_lvl = 3'd3;
        step();
        check("R7 original mask used", stopped, 0);
        irq_lvl = 3'd0;
        step();

        // R8: reset wakes regardless of mask
        enter_stop(3'd7);
        check("R8 stopped before reset", stopped, 1);
        rst = 1'b1;
        step();
        check("R8 reset wakes", sys_clk_en, 1);
        rst = 1'b0;
        step();

        // R9 R10: module stop bits
        stop_wr = 1'b1; stop_wdata = 4'b0101;
        step();
        stop_wr = 1'b0;
        check("R9 stop_bits readback", stop_bits, 4'b0101);
        check("R10 mod_clk_en running", mod_clk_en, 4'b1010);
        enter_stop(3'd4);
        check("R10 mod_clk_en while stopped", mod_clk_en, 4'b0000);
        stop_wr = 1'b1; stop_wdata = 4'b0011;
        step();
        stop_wr = 1'b0;
        check("R9 write while stopped", stop_bits, 4'b0011);
        check("R10 still gated", mod_clk_en, 4'b0000);
        irq_lvl = 3'd5;
        step();
        irq_lvl = 3'd0;
        check("R10 mod_clk_en after wake", mod_clk_en, 4'b1100);
        check("R9 bits kept through wake", stop_bits, 4'b0011);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule